// File: doc/BRIEF.md
# Segment Selector Protection Checker

This unit translates a segmented memory reference into a flat linear address and enforces the access rules in a single step. Each request carries a 16-bit segment selector, an offset, an access kind (instruction fetch, data read or data write) and the privilege ring of the running code. The selector picks one of two descriptor tables: a shared global one, or a local one that belongs to the current task. It also picks a slot in that table and carries a requested privilege ring. The unit reads the descriptor in that slot and checks whether the slot exists, whether the segment is present, whether the privilege rings allow the access, whether the access kind suits the segment kind, and whether the offset lies inside the segment limit.

A request that passes every check returns the segment base plus the offset. A request that breaks any rule returns a 3-bit fault code, and its address is forced to zero. Both tables are small internal RAMs. They are filled through a write-only configuration port and are not cleared by reset, so they must be loaded before use. The result appears on the clock edge after the request is taken.

Top module: `segchk_top`

## Requirements
- R1: The selector is decoded as slot index in bits 15:3, table choice in bit 2 (0 = global, 1 = local) and requested ring in bits 1:0. A slot index equal to or above the table depth raises fault code 2.
- R2: A selector with slot index 0 and table bit 0 is a null selector. It raises fault code 1 for every access kind. Slot 0 of the local table is an ordinary slot.
- R3: A descriptor whose present flag is clear raises fault code 3.
- R4: The effective ring is the larger of the current ring and the requested ring. Ring 0 is the most privileged and ring 3 the least. When the descriptor ring is numerically below the effective ring, fault code 4 is raised.
- R5: The access kind is coded as 0 = fetch, 1 = read, 2 = write, 3 = illegal. A fetch needs a code segment. A read needs either a data segment or a code segment with its rw flag set. A write needs a data segment with its rw flag set. The illegal code always fails. Any breach raises fault code 5.
- R6: An offset strictly greater than the segment limit raises fault code 6. An offset equal to the limit is allowed.
- R7: With fault code 0, the address is the base plus the zero-extended offset, modulo 2^ADDR_W. With any other fault code, the address is 0.
- R8: The outputs rsp_valid, rsp_fault and rsp_addr are registered. rsp_valid is high exactly one cycle after req_valid was high. While rsp_valid is low, and in reset, rsp_fault and rsp_addr are 0.
- R9: When several rules fail at once, the reported code follows this priority: null (1), out of range (2), not present (3), privilege (4), type (5), limit (6).
- R10: A configuration write updates only the slot addressed in the table chosen by cfg_tbl. A request in the same cycle still reads the old contents of that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_tbl | input | 1 | Table written: 0 global, 1 local |
| cfg_idx | input | IDX_W | Slot written |
| cfg_base | input | ADDR_W | Segment base |
| cfg_limit | input | OFS_W | Segment limit (last valid offset) |
| cfg_present | input | 1 | Present flag |
| cfg_ring | input | 2 | Descriptor privilege ring |
| cfg_code | input | 1 | 1 = code segment, 0 = data segment |
| cfg_rw | input | 1 | Readable (code) or writable (data) |
| req_valid | input | 1 | Request strobe |
| req_sel | input | 16 | Segment selector |
| req_ofs | input | OFS_W | Offset inside the segment |
| req_acc | input | 2 | Access kind |
| req_cpl | input | 2 | Current privilege ring |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 3 | Fault code, 0 = granted |
| rsp_addr | output | ADDR_W | Linear address when granted |

## Verification
The bench keeps its own copy of both tables and recomputes every response on the next cycle. A corrupted descriptor slot, a wrong table choice or a misplaced field boundary therefore shows up on the first request that touches that slot, as a wrong fault code or a wrong address one clock after the request. A wrong priority between rules only shows up when two rules fail together. For that reason the directed part builds selectors that break several rules at once, and the random part mixes out-of-range slots, absent segments and all ring combinations.

// File: rtl/segchk_pkg.sv
package segchk_pkg;
  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_NULL   = 3'd1,
    FLT_RANGE  = 3'd2,
    FLT_ABSENT = 3'd3,
    FLT_PRIV   = 3'd4,
    FLT_TYPE   = 3'd5,
    FLT_LIMIT  = 3'd6
  } fault_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_BAD   = 2'd3
  } acc_e;

  typedef struct packed {
    logic       present;
    logic [1:0] ring;
    logic       code;
    logic       rw;
  } attr_t;

  localparam int ATTR_W = $bits(attr_t);
endpackage

// File: rtl/segchk_table.sv
module segchk_table #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int WORD_W = 53
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/segchk_rules.sv
module segchk_rules
  import segchk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16
) (
  input  logic              is_null,
  input  logic              out_of_range,
  input  attr_t             attr,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  limit,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [1:0]        acc,
  input  logic [1:0]        cpl,
  input  logic [1:0]        rpl,
  output fault_e            fault,
  output logic [ADDR_W-1:0] addr
);
  logic [1:0] eff_ring;
  logic       type_ok;

  always_comb begin
    eff_ring = (cpl > rpl) ? cpl : rpl;
    case (acc_e'(acc))
      ACC_FETCH: type_ok = attr.code;
      ACC_READ:  type_ok = !attr.code || attr.rw;
      ACC_WRITE: type_ok = !attr.code && attr.rw;
      default:   type_ok = 1'b0;
    endcase

    if (is_null)                   fault = FLT_NULL;
    else if (out_of_range)         fault = FLT_RANGE;
    else if (!attr.present)        fault = FLT_ABSENT;
    else if (attr.ring < eff_ring) fault = FLT_PRIV;
    else if (!type_ok)             fault = FLT_TYPE;
    else if (ofs > limit)          fault = FLT_LIMIT;
    else                           fault = FLT_NONE;

    addr = (fault == FLT_NONE) ? base + ADDR_W'(ofs) : '0;
  end
endmodule

// File: rtl/segchk_top.sv
module segchk_top
  import segchk_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_tbl,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [OFS_W-1:0]  cfg_limit,
  input  logic              cfg_present,
  input  logic [1:0]        cfg_ring,
  input  logic              cfg_code,
  input  logic              cfg_rw,
  input  logic              req_valid,
  input  logic [15:0]       req_sel,
  input  logic [OFS_W-1:0]  req_ofs,
  input  logic [1:0]        req_acc,
  input  logic [1:0]        req_cpl,
  output logic              rsp_valid,
  output logic [2:0]        rsp_fault,
  output logic [ADDR_W-1:0] rsp_addr
);
  localparam int WORD_W  = ATTR_W + OFS_W + ADDR_W;
  localparam int NTABLES = 2;
  localparam int SLOT_W  = 13;

  logic [WORD_W-1:0] wword;
  logic [WORD_W-1:0] rword [NTABLES];
  logic [WORD_W-1:0] sel_word;
  logic [SLOT_W-1:0] slot;
  logic [IDX_W-1:0]  raddr;
  logic              tbl_bit;
  attr_t             cfg_attr;
  attr_t             rd_attr;
  logic [OFS_W-1:0]  rd_limit;
  logic [ADDR_W-1:0] rd_base;
  fault_e            chk_fault;
  logic [ADDR_W-1:0] chk_addr;

  assign slot     = req_sel[15:3];
  assign tbl_bit  = req_sel[2];
  assign raddr    = slot[IDX_W-1:0];
  assign cfg_attr = '{present: cfg_present, ring: cfg_ring, code: cfg_code, rw: cfg_rw};
  assign wword    = {cfg_attr, cfg_limit, cfg_base};

  for (genvar g = 0; g < NTABLES; g++) begin : g_tbl
    segchk_table #(.DEPTH(DEPTH), .IDX_W(IDX_W), .WORD_W(WORD_W)) u_tbl (
      .clk   (clk),
      .we    (cfg_we && (cfg_tbl == g[0])),
      .waddr (cfg_idx),
      .wdata (wword),
      .raddr (raddr),
      .rdata (rword[g])
    );
  end

  assign sel_word = rword[tbl_bit];
  assign {rd_attr, rd_limit, rd_base} = sel_word;

  segchk_rules #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_rules (
    .is_null      (slot == '0 && !tbl_bit),
    .out_of_range (32'(slot) >= DEPTH),
    .attr         (rd_attr),
    .base         (rd_base),
    .limit        (rd_limit),
    .ofs          (req_ofs),
    .acc          (req_acc),
    .cpl          (req_cpl),
    .rpl          (req_sel[1:0]),
    .fault        (chk_fault),
    .addr         (chk_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= '0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid ? chk_fault : FLT_NONE;
      rsp_addr  <= req_valid ? chk_addr : '0;
    end
  end
endmodule

// File: rtl/segchk_sva.sv
module segchk_sva #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [15:0]       req_sel,
  input logic [1:0]        req_acc,
  input logic              rsp_valid,
  input logic [2:0]        rsp_fault,
  input logic [ADDR_W-1:0] rsp_addr
);
  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rsp_valid == $past(req_valid));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_fault == 3'd0 && rsp_addr == '0));

  p_fault_addr_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 3'd0) |-> rsp_addr == '0);

  p_null_sel_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid) && $past(req_sel[15:2]) == 14'd0) |-> rsp_fault == 3'd1);

  p_bad_acc_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid) && $past(req_acc) == 2'd3) |-> rsp_fault != 3'd0);

  p_code_set_r1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_fault <= 3'd6);
endmodule

bind segchk_top segchk_sva #(.ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/sim_segchk_top.sv
module sim_segchk_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int IDX_W  = 3;
  localparam int ADDR_W = 32;
  localparam int OFS_W  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 0, cfg_tbl = 0, cfg_present = 0, cfg_code = 0, cfg_rw = 0;
  logic [IDX_W-1:0]  cfg_idx = '0;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic [OFS_W-1:0]  cfg_limit = '0;
  logic [1:0]        cfg_ring = '0;
  logic              req_valid = 0;
  logic [15:0]       req_sel = '0;
  logic [OFS_W-1:0]  req_ofs = '0;
  logic [1:0]        req_acc = '0, req_cpl = '0;
  logic              rsp_valid;
  logic [2:0]        rsp_fault;
  logic [ADDR_W-1:0] rsp_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  segchk_top #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .OFS_W(OFS_W)) u0 (.*);

  // reference tables: [table][slot]
  logic [ADDR_W-1:0] m_base  [2][DEPTH];
  logic [OFS_W-1:0]  m_limit [2][DEPTH];
  logic              m_pres  [2][DEPTH];
  logic [1:0]        m_ring  [2][DEPTH];
  logic              m_code  [2][DEPTH];
  logic              m_rw    [2][DEPTH];

  int checks = 0, errors = 0;
  bit have_exp = 0;
  logic exp_valid; logic [2:0] exp_fault; logic [ADDR_W-1:0] exp_addr;
  string exp_tag;

  function automatic string tag_of(input logic [2:0] f);
    case (f)
      3'd0: return "R7"; 3'd1: return "R2"; 3'd2: return "R1";
      3'd3: return "R3"; 3'd4: return "R4"; 3'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic cmp(input string tag, input logic v, input logic [2:0] f, input logic [ADDR_W-1:0] a);
    checks++;
    if (rsp_valid !== v || rsp_fault !== f || rsp_addr !== a) begin
      errors++;
      $display("FAIL %s: got valid=%b fault=%0d addr=%h, expected valid=%b fault=%0d addr=%h",
               tag, rsp_valid, rsp_fault, rsp_addr, v, f, a);
    end
  endtask

  // one cycle: check previous response, drive new inputs, predict
  task automatic step(input string tag, input logic v, input int idx, input logic tbl,
                      input logic [1:0] rpl, input logic [OFS_W-1:0] ofs,
                      input logic [1:0] acc, input logic [1:0] cpl,
                      input logic we, input logic wt, input int wi, input logic [ADDR_W-1:0] wb,
                      input logic [OFS_W-1:0] wl, input logic wp, input logic [1:0] wr,
                      input logic wc, input logic ww);
    int t; int eff; bit tok; logic [2:0] f;
    @(negedge clk);
    if (have_exp) cmp(exp_tag, exp_valid, exp_fault, exp_addr);
    req_valid = v; req_sel = {13'(idx), tbl, rpl}; req_ofs = ofs; req_acc = acc; req_cpl = cpl;
    cfg_we = we; cfg_tbl = wt; cfg_idx = IDX_W'(wi); cfg_base = wb; cfg_limit = wl;
    cfg_present = wp; cfg_ring = wr; cfg_code = wc; cfg_rw = ww;
    t = tbl ? 1 : 0;
    eff = (cpl > rpl) ? cpl : rpl;
    f = 3'd0;
    if (idx == 0 && !tbl) f = 3'd1;
    else if (idx >= DEPTH) f = 3'd2;
    else begin
      case (acc)
        2'd0: tok = m_code[t][idx];
        2'd1: tok = !m_code[t][idx] || m_rw[t][idx];
        2'd2: tok = !m_code[t][idx] && m_rw[t][idx];
        default: tok = 0;
      endcase
      if (!m_pres[t][idx]) f = 3'd3;
      else if (int'(m_ring[t][idx]) < eff) f = 3'd4;
      else if (!tok) f = 3'd5;
      else if (ofs > m_limit[t][idx]) f = 3'd6;
    end
    exp_valid = v;
    exp_fault = v ? f : 3'd0;
    exp_addr  = (v && f == 0) ? m_base[t][idx] + ADDR_W'(ofs) : '0;
    exp_tag   = (tag == "") ? (v ? tag_of(f) : "R8") : tag;
    have_exp  = 1;
    if (we) begin
      t = wt ? 1 : 0;
      m_base[t][wi] = wb; m_limit[t][wi] = wl; m_pres[t][wi] = wp;
      m_ring[t][wi] = wr; m_code[t][wi] = wc; m_rw[t][wi] = ww;
    end
  endtask

  task automatic load(input logic t, input int i, input logic [ADDR_W-1:0] b, input logic [OFS_W-1:0] l,
                      input logic p, input logic [1:0] r, input logic c, input logic w);
    step("R8", 0, 1, 0, 0, 0, 0, 0, 1, t, i, b, l, p, r, c, w);
  endtask

  task automatic rq(input string tag, input int idx, input logic tbl, input logic [1:0] rpl,
                    input logic [OFS_W-1:0] ofs, input logic [1:0] acc, input logic [1:0] cpl);
    step(tag, 1, idx, tbl, rpl, ofs, acc, cpl, 0, 0, 0, '0, '0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    $display("FAIL watchdog: got timeout, expected end of run");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R8", 0, 3'd0, '0);            // reset state
    rst = 0;
    // fill both tables with a background pattern
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < DEPTH; i++)
        load(t[0], i, 32'h100 * (i + 16*t), 16'h80, 1, 2'(i), i[0], i[1]);
    load(0, 1, 32'h0000_1000, 16'h00FF, 1, 0, 1, 1); // code readable ring0
    load(0, 2, 32'hFFFF_FF80, 16'h00FF, 1, 3, 0, 1); // data writable ring3
    load(0, 3, 32'h0000_5000, 16'h00FF, 0, 0, 0, 1); // absent ring0
    load(0, 4, 32'h0000_2000, 16'h0010, 1, 3, 1, 0); // code exec-only ring3
    load(0, 5, 32'h0000_3000, 16'h0040, 1, 2, 0, 0); // data read-only ring2
    load(1, 0, 32'h0000_4000, 16'h0020, 1, 3, 0, 1); // local slot0 data rw
    rq("R7", 2, 0, 0, 16'h0090, 2, 0);   // base+ofs wraps
    rq("R6", 4, 0, 3, 16'h0010, 0, 3);   // offset == limit granted
    rq("R6", 4, 0, 3, 16'h0011, 0, 3);   // limit+1 faults
    rq("R2", 0, 0, 3, 16'h0000, 0, 0);   // null selector
    rq("R2", 0, 1, 0, 16'h0004, 2, 0);   // local slot0 is fine
    rq("R1", 8, 0, 0, 16'h0000, 1, 0);   // slot beyond depth
    rq("R1", 8, 1, 0, 16'h0000, 1, 0);
    rq("R3", 3, 0, 0, 16'h0000, 1, 0);   // absent
    rq("R4", 1, 0, 0, 16'h0000, 0, 1);   // cpl drags ring
    rq("R4", 1, 0, 2, 16'h0000, 0, 0);   // rpl drags ring
    rq("R4", 5, 0, 0, 16'h0000, 1, 2);   // ring equal allowed
    rq("R5", 4, 0, 0, 16'h0000, 1, 0);   // read exec-only code
    rq("R5", 1, 0, 0, 16'h0000, 2, 0);   // write code
    rq("R5", 5, 0, 0, 16'h0000, 2, 0);   // write read-only data
    rq("R5", 1, 0, 0, 16'h0000, 1, 0);   // read readable code granted
    rq("R5", 2, 0, 0, 16'h0000, 3, 0);   // illegal access kind
    rq("R9", 0, 0, 0, 16'hFFFF, 3, 3);   // null beats all
    rq("R9", 3, 0, 3, 16'hFFFF, 3, 3);   // absent beats ring/type/limit
    rq("R9", 4, 0, 0, 16'hFFFF, 2, 3);   // ring ok? ring3: type beats limit
    rq("R9", 5, 0, 3, 16'hFFFF, 2, 3);   // ring beats type and limit
    // same-cycle write and read of one slot: old contents seen
    step("R10", 1, 2, 0, 0, 16'h0001, 1, 0, 1, 0, 2, 32'h0000_9000, 16'h0001, 0, 0, 0, 0);
    rq("R10", 2, 0, 0, 16'h0001, 1, 0);  // now absent
    step("R10", 1, 0, 1, 0, 16'h0001, 1, 0, 1, 0, 0, 32'h0, 16'h0, 0, 0, 0, 0);
    rq("R10", 0, 1, 0, 16'h0001, 1, 0);  // local slot0 untouched
    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      bit v = ($urandom_range(0, 4) != 0);
      bit w = ($urandom_range(0, 9) == 0);
      step("", v, $urandom_range(0, 9), 1'($urandom), 2'($urandom), 16'($urandom_range(0, 16'h1FF)),
           2'($urandom), 2'($urandom), w, 1'($urandom), $urandom_range(0, DEPTH-1), $urandom,
           16'($urandom_range(0, 16'h180)), ($urandom_range(0, 5) != 0), 2'($urandom),
           1'($urandom), 1'($urandom));
    end
    step("R8", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, '0, '0, 0, 0, 0, 0);
    @(negedge clk);
    cmp(exp_tag, exp_valid, exp_fault, exp_addr);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule